// File: doc/BRIEF.md
# Reloadable Time-Base Divider

The block divides a slow real-time clock into a periodic one-cycle tick that paces a seconds counter. A 20-bit down-counter steps once per input clock. When it has reached zero, the block pulses the tick for one cycle and refills the counter from a programmed reload value. With a reload value of R, the tick period is R + 1 input clocks. For example, a 32.768 kHz clock with R = 0x7FFF gives one tick per second. A reload value of zero is not supported.

Software sees four 16-bit registers, selected by a 2-bit index:

| Index | Access | Contents |
|---|---|---|
| 0 | write-only | Low half of the reload value |
| 1 | write-only | Reload bits 19:16 |
| 2 | read-only | Live count bits 15:0 |
| 3 | read-only | Live count bits 19:16 |

The live count can be read at any time without disturbing it. A write to either reload register forces the counter to refill. So does a one-cycle pulse on an input that reports a write to the external seconds counter. In both cases the next count period starts cleanly from the new value.

Top module: `rtc_tick_divider`

## Requirements
- R1: While reset is high and on the first cycle after it, `tick` is 0. Index 2 reads 0x8000 and index 3 reads 0x0000, because the count and the reload value both reset to 0x08000.
- R2: With no forced reload and a nonzero count, the count drops by exactly one per clock. Index 2 returns count bits 15:0. Index 3 returns count bits 19:16 in bits 3:0, with bits 15:4 read as 0.
- R3: On the edge where the count is 0, the count is refilled from the reload value and `tick` is 1 for exactly the following cycle. The tick period for reload value R is therefore R + 1 clocks.
- R4: A write to index 0 replaces reload bits 15:0. A write to index 1 replaces reload bits 19:16 with write data bits 3:0 and discards write data bits 15:4.
- R5: A write to index 0 or index 1 loads the counter on that same edge with the updated reload value, and `tick` is 0 in the following cycle. This holds even when the count is 0 at that edge.
- R6: A one-cycle pulse on `time_cnt_written` loads the counter with the current reload value on that edge, and `tick` is 0 in the following cycle.
- R7: Reading index 0 or index 1 returns 0. Selecting any index for a read never changes the count or the tick sequence.
- R8: Writes to index 2 or index 3 change neither the reload value nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Real-time input clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register index: 0 reload low, 1 reload high, 2 count low, 3 count high |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| time_cnt_written | input | 1 | One-cycle pulse: the external seconds counter was written |
| tick | output | 1 | One-cycle time-base tick |

## Verification
The bench builds the block with its default parameters: a 20-bit counter, 16-bit registers and a reset reload value of 0x08000. Running one full reset-value period exercises a 32769-cycle tick interval. It also shows bit 15 of the count clearing on schedule.

Reprogramming small reload values then brings many wraps, forced reloads landing on a zero count, and reserved-bit writes within a few thousand cycles. A directed setting of reload bit 16 makes the high count register read nonzero.

// File: rtl/rtc_pscl_pkg.sv
package rtc_pscl_pkg;

    localparam int REG_W = 16;

    typedef enum logic [1:0] {
        SEL_RLD_LO = 2'd0,
        SEL_RLD_HI = 2'd1,
        SEL_CNT_LO = 2'd2,
        SEL_CNT_HI = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             we;
        reg_sel_e         sel;
        logic [REG_W-1:0] data;
    } reg_wr_t;

    function automatic logic is_reload_sel(reg_sel_e s);
        return (s == SEL_RLD_LO) || (s == SEL_RLD_HI);
    endfunction

endpackage

// File: rtl/rtc_reload_regs.sv
module rtc_reload_regs
    import rtc_pscl_pkg::*;
#(
    parameter int               DIV_W   = 20,
    parameter logic [DIV_W-1:0] RST_VAL = 20'h08000
) (
    input  logic             clk,
    input  logic             rst,
    input  reg_wr_t          wr,
    input  logic             cnt_written,
    output logic [DIV_W-1:0] rld_q,
    output logic [DIV_W-1:0] rld_next,
    output logic             load_req
);
    localparam int HI_W = DIV_W - REG_W;

    always_comb begin
        rld_next = rld_q;
        load_req = cnt_written;
        if (wr.we && is_reload_sel(wr.sel)) begin
            load_req = 1'b1;
            if (wr.sel == SEL_RLD_LO)
                rld_next[REG_W-1:0] = wr.data;
            else
                rld_next[DIV_W-1:REG_W] = wr.data[HI_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rld_q <= RST_VAL;
        else
            rld_q <= rld_next;
    end

endmodule

// File: rtl/rtc_down_counter.sv
module rtc_down_counter #(
    parameter int               DIV_W   = 20,
    parameter logic [DIV_W-1:0] RST_VAL = 20'h08000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    input  logic [DIV_W-1:0] rld_q,
    output logic [DIV_W-1:0] cnt_q,
    output logic             tick_q
);
    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= RST_VAL;
            tick_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= load_val;
            tick_q <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q  <= rld_q;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q - ONE;
            tick_q <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
    import rtc_pscl_pkg::*;
#(
    parameter int DIV_W = 20
) (
    input  reg_sel_e         sel,
    input  logic [DIV_W-1:0] cnt,
    output logic [REG_W-1:0] rdata
);
    localparam int HI_W  = DIV_W - REG_W;
    localparam int PAD_W = REG_W - HI_W;

    logic [REG_W-1:0] hi_word;

    generate
        if (PAD_W > 0) begin : g_pad
            assign hi_word = {{PAD_W{1'b0}}, cnt[DIV_W-1:REG_W]};
        end else begin : g_full
            assign hi_word = cnt[REG_W+REG_W-1:REG_W];
        end
    endgenerate

    always_comb begin
        unique case (sel)
            SEL_CNT_LO: rdata = cnt[REG_W-1:0];
            SEL_CNT_HI: rdata = hi_word;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_tick_divider.sv
module rtc_tick_divider
    import rtc_pscl_pkg::*;
#(
    parameter int               DIV_W      = 20,
    parameter logic [DIV_W-1:0] RST_RELOAD = 20'h08000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  reg_sel,
    input  logic        reg_we,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        time_cnt_written,
    output logic        tick
);
    reg_wr_t          wr;
    logic [DIV_W-1:0] rld_q;
    logic [DIV_W-1:0] rld_next;
    logic             load_req;
    logic [DIV_W-1:0] cnt_q;

    assign wr.we   = reg_we;
    assign wr.sel  = reg_sel_e'(reg_sel);
    assign wr.data = reg_wdata;

    rtc_reload_regs #(
        .DIV_W  (DIV_W),
        .RST_VAL(RST_RELOAD)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr),
        .cnt_written(time_cnt_written),
        .rld_q      (rld_q),
        .rld_next   (rld_next),
        .load_req   (load_req)
    );

    rtc_down_counter #(
        .DIV_W  (DIV_W),
        .RST_VAL(RST_RELOAD)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (load_req),
        .load_val(rld_next),
        .rld_q   (rld_q),
        .cnt_q   (cnt_q),
        .tick_q  (tick)
    );

    rtc_read_mux #(
        .DIV_W(DIV_W)
    ) u_rd (
        .sel  (reg_sel_e'(reg_sel)),
        .cnt  (cnt_q),
        .rdata(reg_rdata)
    );

endmodule

// File: rtl/rtc_tick_divider_chk.sv
module rtc_tick_divider_chk #(
    parameter int               DIV_W      = 20,
    parameter logic [DIV_W-1:0] RST_RELOAD = 20'h08000
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       reg_sel,
    input logic             reg_we,
    input logic [15:0]      reg_rdata,
    input logic             cw,
    input logic             tick,
    input logic [DIV_W-1:0] cnt,
    input logic [DIV_W-1:0] rld,
    input logic             load
);
    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (cnt == RST_RELOAD && rld == RST_RELOAD && !tick));

    assert_step_down_R2: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - ONE && !tick));

    assert_hi_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 2'd3) |-> (reg_rdata[15:4] == 12'h000));

    assert_wrap_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt == '0) |=> (tick && cnt == $past(rld)));

    assert_forced_load_R5: assert property (@(posedge clk) disable iff (rst)
        load |=> (!tick && cnt == rld));

    assert_pulse_loads_R6: assert property (@(posedge clk) disable iff (rst)
        cw |-> load);

    assert_reload_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_sel[1] == 1'b0) |-> (reg_rdata == 16'h0000));

    assert_count_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_sel[1] && !cw) |=> (rld == $past(rld)));

endmodule

bind rtc_tick_divider rtc_tick_divider_chk #(
    .DIV_W     (DIV_W),
    .RST_RELOAD(RST_RELOAD)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_sel  (reg_sel),
    .reg_we   (reg_we),
    .reg_rdata(reg_rdata),
    .cw       (time_cnt_written),
    .tick     (tick),
    .cnt      (cnt_q),
    .rld      (rld_q),
    .load     (load_req)
);

// File: tb/rtc_tick_divider_tb_top.sv
`timescale 1ns/1ps
module rtc_tick_divider_tb_top;
    localparam int DW = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  sel = 2'd2;
    logic        we  = 1'b0;
    logic [15:0] wd  = 16'h0000;
    logic        cw  = 1'b0;
    wire  [15:0] rd;
    wire         tick;

    int n_chk  = 0;
    int n_fail = 0;
    int n_ticks;

    logic [DW-1:0] m_cnt = 20'h08000;
    logic [DW-1:0] m_rld = 20'h08000;
    logic          m_tick = 1'b0;

    always #4 clk = ~clk;

    rtc_tick_divider dut_i (
        .clk             (clk),
        .rst             (rst),
        .reg_sel         (sel),
        .reg_we          (we),
        .reg_wdata       (wd),
        .reg_rdata       (rd),
        .time_cnt_written(cw),
        .tick            (tick)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(logic [1:0] s, logic [DW-1:0] c);
        if (s == 2'd2) return c[15:0];
        if (s == 2'd3) return {12'h000, c[19:16]};
        return 16'h0000;
    endfunction

    // One clock: drive at the falling edge, advance the model, check at the next falling edge.
    task automatic step(bit w, logic [1:0] s, logic [15:0] d, bit c);
        logic [DW-1:0] rn;
        bit            ld;
        string         tag;
        we = w; sel = s; wd = d; cw = c;
        rn = m_rld;
        ld = c;
        tag = c ? "R6" : "R3";
        if (w && s == 2'd0) begin rn[15:0]  = d;      ld = 1'b1; tag = "R4/R5"; end
        if (w && s == 2'd1) begin rn[19:16] = d[3:0]; ld = 1'b1; tag = "R4/R5"; end
        if (w && s[1]) tag = "R8";
        @(posedge clk);
        @(negedge clk);
        if (ld) begin
            m_cnt = rn; m_tick = 1'b0;
        end else if (m_cnt == '0) begin
            m_cnt = m_rld; m_tick = 1'b1;
        end else begin
            m_cnt = m_cnt - 1'b1; m_tick = 1'b0;
        end
        m_rld = rn;
        we = 1'b0; cw = 1'b0;
        if (tick) n_ticks++;
        chk({tag, " tick"}, {31'd0, tick}, {31'd0, m_tick});
        chk(s[1] ? "R2 count read" : "R7 reload read", {16'd0, rd}, {16'd0, exp_read(s, m_cnt)});
    endtask

    task automatic idle(int n, logic [1:0] s);
        for (int i = 0; i < n; i++) step(1'b0, s, 16'h0000, 1'b0);
    endtask

    initial begin
        repeat (250000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        // R1: state during and just after reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        sel = 2'd2; #1;
        chk("R1 count low in reset", {16'd0, rd}, 32'h8000);
        chk("R1 tick in reset", {31'd0, tick}, 32'd0);
        sel = 2'd3; #1;
        chk("R1 count high in reset", {16'd0, rd}, 32'h0000);
        rst = 1'b0;
        // R1 and R2: first cycle after reset still reads the reset value minus one
        step(1'b0, 2'd2, 16'h0, 1'b0);

        // R3: full reset-value period, ending in exactly one tick
        n_ticks = 0;
        idle(32768, 2'd2);
        chk("R3 single tick over reset period", n_ticks, 1);

        // R4: reserved bits of the high write are discarded; small period
        step(1'b1, 2'd1, 16'hFFF0, 1'b0);
        step(1'b1, 2'd0, 16'h0005, 1'b0);
        n_ticks = 0;
        idle(18, 2'd3);
        chk("R3 three ticks at period 6", n_ticks, 3);

        // R2: reload bit 16 visible in the high count register
        step(1'b1, 2'd1, 16'h0001, 1'b0);
        step(1'b1, 2'd0, 16'h0003, 1'b0);
        idle(6, 2'd3);
        idle(4, 2'd2);
        step(1'b1, 2'd1, 16'hABC0, 1'b0);
        n_ticks = 0;
        idle(8, 2'd2);
        chk("R4 period 4 after reserved write", n_ticks, 2);

        // R5: reload write lands on a zero count
        while (m_cnt != '0) step(1'b0, 2'd2, 16'h0, 1'b0);
        step(1'b1, 2'd0, 16'h0007, 1'b0);
        idle(3, 2'd2);
        // R6: external pulse lands on a zero count, and mid-count
        while (m_cnt != '0) step(1'b0, 2'd2, 16'h0, 1'b0);
        step(1'b0, 2'd2, 16'h0, 1'b1);
        idle(3, 2'd2);
        step(1'b0, 2'd2, 16'h0, 1'b1);
        idle(4, 2'd2);

        // R8: writes to count registers are ignored
        step(1'b1, 2'd2, 16'hFFFF, 1'b0);
        step(1'b1, 2'd3, 16'h000F, 1'b0);
        idle(12, 2'd2);

        // R7: reading reload registers leaves the sequence untouched
        idle(10, 2'd0);
        idle(10, 2'd1);

        // Mixed random traffic with small reload values
        for (int it = 0; it < 4000; it++) begin
            int unsigned r;
            r = $urandom % 12;
            case (r)
                0: step(1'b1, 2'd0, 16'(1 + $urandom % 40), 1'b0);
                1: step(1'b1, 2'd1, {12'($urandom), 4'h0}, 1'b0);
                2: step(1'b0, 2'($urandom), 16'h0, 1'b1);
                3: step(1'b1, {1'b1, 1'($urandom)}, 16'($urandom), 1'b0);
                default: step(1'b0, 2'($urandom), 16'h0, 1'b0);
            endcase
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule